// File: doc/BRIEF.md
# Dual Data Pointer Register File

This block holds the two 16-bit data pointers of an 8051-class core. Each pointer's low and high bytes are special-function-register bytes at their own addresses. The first pair sits at the classic pointer addresses, 82h (low) and 83h (high), so software written for a single pointer runs unchanged. The second pair uses the spare addresses 84h (low) and 85h (high). Bit 0 of a select register at 86h chooses the active pointer.

The instruction decoder drives single-cycle increment and decrement strobes. The decrement strobe serves the decrement-pointer instruction, opcode A5h. Both strobes act only on the active pointer. The active pointer is always presented on a 16-bit output that addresses external data memory. SFR reads are combinational.

Top module: `dptr_pair`

## Requirements
- R1: After reset, all four pointer bytes read 00h, the select register reads 00h, and `ptr_addr` is 0000h.
- R2: A write with `sfr_we` high to 82h, 83h, 84h or 85h loads only that byte: 82h is pointer 0 low, 83h is pointer 0 high, 84h is pointer 1 low, and 85h is pointer 1 high. The new value is readable combinationally on `sfr_rdata` from the next cycle.
- R3: A write to 86h stores only bit 0 as the select bit. A read of 86h returns {7'b0, select}.
- R4: `ptr_addr` always equals the pointer named by the select bit (0 for pointer 0, 1 for pointer 1).
- R5: `ptr_inc` alone adds 1 to the active pointer, with carry across all 16 bits. FFFFh wraps to 0000h, and the other pointer is unchanged.
- R6: `ptr_dec` alone subtracts 1 from the active pointer, with borrow across all 16 bits. 0000h wraps to FFFFh, and the other pointer is unchanged.
- R7: When `ptr_inc` and `ptr_dec` are high together, neither pointer changes.
- R8: An SFR write to a byte of the active pointer in the same cycle as a strobe stores the written byte. The pointer's other byte is kept, and no arithmetic takes place.
- R9: An SFR write to a byte of the inactive pointer in the same cycle as a strobe performs both the write and the arithmetic on the active pointer.
- R10: Addresses other than 82h–86h read 00h, and writes to them change nothing.
- R11: When the select register is written in the same cycle as a strobe, the arithmetic applies to the pointer that was active before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_dec | input | 1 | Decrement the active pointer |
| ptr_addr | output | 16 | Active pointer value |

## Verification
The hardest cases are the ones where an SFR write and an arithmetic strobe land in the same clock edge. The outcome then depends on whether the written byte belongs to the active pointer, to the inactive one, or to the select register. The bench builds each of these collisions directly. It loads both pointers with distinct values first, so that any leakage of the arithmetic into the wrong pointer or byte shows up as a changed readback. The carry and borrow paths are swept across every low-byte value under several high bytes, on alternating pointers.

// File: rtl/dptr_pair.sv
module dptr_pair #(
  parameter logic [7:0] LO0_ADDR = 8'h82,
  parameter logic [7:0] HI0_ADDR = 8'h83,
  parameter logic [7:0] LO1_ADDR = 8'h84,
  parameter logic [7:0] HI1_ADDR = 8'h85,
  parameter logic [7:0] SEL_ADDR = 8'h86,
  parameter int         NPTR     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  input  logic        sfr_we,
  output logic [7:0]  sfr_rdata,
  input  logic        ptr_inc,
  input  logic        ptr_dec,
  output logic [15:0] ptr_addr
);
  localparam int SW = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [15:0] ptr [NPTR];
  logic [SW-1:0] sel;

  wire step = ptr_inc ^ ptr_dec;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [7:0] LA = (g == 0) ? LO0_ADDR : LO1_ADDR;
    localparam logic [7:0] HA = (g == 0) ? HI0_ADDR : HI1_ADDR;
    wire wr_lo = sfr_we && (sfr_addr == LA);
    wire wr_hi = sfr_we && (sfr_addr == HA);
    wire act   = (sel == SW'(g));
    wire [15:0] nxt = ptr_inc ? ptr[g] + 16'd1 : ptr[g] - 16'd1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr[g] <= '0;
      end else if (wr_lo || wr_hi) begin
        if (wr_lo) ptr[g][7:0]  <= sfr_wdata;
        if (wr_hi) ptr[g][15:8] <= sfr_wdata;
      end else if (act && step) begin
        ptr[g] <= nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel <= '0;
    else if (sfr_we && sfr_addr == SEL_ADDR) sel <= sfr_wdata[SW-1:0];
  end

  assign ptr_addr = ptr[sel];

  always_comb begin
    unique case (sfr_addr)
      LO0_ADDR: sfr_rdata = ptr[0][7:0];
      HI0_ADDR: sfr_rdata = ptr[0][15:8];
      LO1_ADDR: sfr_rdata = ptr[1][7:0];
      HI1_ADDR: sfr_rdata = ptr[1][15:8];
      SEL_ADDR: sfr_rdata = 8'(sel);
      default:  sfr_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk #(
  parameter logic [7:0] LO0_ADDR = 8'h82,
  parameter logic [7:0] HI0_ADDR = 8'h83,
  parameter logic [7:0] LO1_ADDR = 8'h84,
  parameter logic [7:0] HI1_ADDR = 8'h85,
  parameter logic [7:0] SEL_ADDR = 8'h86
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic [7:0]  sfr_wdata,
  input logic        sfr_we,
  input logic [7:0]  sfr_rdata,
  input logic        ptr_inc,
  input logic        ptr_dec,
  input logic [15:0] ptr_addr
);
  wire mapped = (sfr_addr == LO0_ADDR) || (sfr_addr == HI0_ADDR) ||
                (sfr_addr == LO1_ADDR) || (sfr_addr == HI1_ADDR) ||
                (sfr_addr == SEL_ADDR);

  a_r5_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_dec && !sfr_we) |=> ptr_addr == $past(ptr_addr) + 16'd1);

  a_r6_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_dec && !ptr_inc && !sfr_we) |=> ptr_addr == $past(ptr_addr) - 16'd1);

  a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr_dec && !sfr_we) |=> $stable(ptr_addr));

  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_dec && !mapped) |=> $stable(ptr_addr));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> sfr_rdata == 8'h00);

  a_r3_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SEL_ADDR) |-> sfr_rdata[7:1] == 7'd0);
endmodule

bind dptr_pair dptr_pair_chk #(
  .LO0_ADDR(LO0_ADDR), .HI0_ADDR(HI0_ADDR),
  .LO1_ADDR(LO1_ADDR), .HI1_ADDR(HI1_ADDR), .SEL_ADDR(SEL_ADDR)
) u_chk (.*);

// File: tb/dptr_pair_bench.sv
`timescale 1ns/10ps
module dptr_pair_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  sfr_addr = 0;
  logic [7:0]  sfr_wdata = 0;
  logic        sfr_we = 0;
  logic [7:0]  sfr_rdata;
  logic        ptr_inc = 0;
  logic        ptr_dec = 0;
  logic [15:0] ptr_addr;

  dptr_pair u_dptr_pair (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] m [2];
  logic        msel;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic we,
                     input logic inc, input logic dec);
    logic [15:0] n0, n1;
    logic        ns, wa;
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = we; ptr_inc = inc; ptr_dec = dec;
    @(posedge clk);
    n0 = m[0]; n1 = m[1]; ns = msel;
    wa = we && (msel ? (a == 8'h84 || a == 8'h85) : (a == 8'h82 || a == 8'h83));
    if (!wa && (inc ^ dec)) begin
      if (msel) n1 = inc ? m[1] + 16'd1 : m[1] - 16'd1;
      else      n0 = inc ? m[0] + 16'd1 : m[0] - 16'd1;
    end
    if (we) case (a)
      8'h82: n0[7:0]  = d;
      8'h83: n0[15:8] = d;
      8'h84: n1[7:0]  = d;
      8'h85: n1[15:8] = d;
      8'h86: ns = d[0];
      default: ;
    endcase
    m[0] = n0; m[1] = n1; msel = ns;
    @(negedge clk);
    sfr_we = 0; ptr_inc = 0; ptr_dec = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a; #0.2;
    chk(req, {8'h00, sfr_rdata}, {8'h00, exp});
  endtask

  task automatic vfy(input string req);
    chk({req, " addr"}, ptr_addr, msel ? m[1] : m[0]);
    rd(req, 8'h82, m[0][7:0]);
    rd(req, 8'h83, m[0][15:8]);
    rd(req, 8'h84, m[1][7:0]);
    rd(req, 8'h85, m[1][15:8]);
    rd(req, 8'h86, {7'd0, msel});
  endtask

  task automatic load(input logic p, input logic [15:0] v);
    cyc(p ? 8'h84 : 8'h82, v[7:0], 1, 0, 0);
    cyc(p ? 8'h85 : 8'h83, v[15:8], 1, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m[0] = 0; m[1] = 0; msel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    vfy("R1 reset");

    load(0, 16'h1234); load(1, 16'hABCD);
    vfy("R2 byte writes");
    cyc(8'h86, 8'hFF, 1, 0, 0); vfy("R3 sel upper bits");
    cyc(8'h86, 8'hFE, 1, 0, 0); vfy("R3 sel clear");
    cyc(8'h86, 8'h01, 1, 0, 0); vfy("R4 select pointer 1");

    // R5/R6 boundary sweep on both pointers
    for (int lo = 0; lo < 256; lo++) begin
      for (int h = 0; h < 3; h++) begin
        logic [7:0] hb;
        logic p;
        hb = (h == 0) ? 8'h00 : (h == 1) ? 8'h7F : 8'hFF;
        p = lo[0] ^ h[0];
        cyc(8'h86, {7'd0, p}, 1, 0, 0);
        load(p, {hb, lo[7:0]});
        cyc(8'h00, 8'h00, 0, 1, 0); vfy("R5 increment");
        cyc(8'h00, 8'h00, 0, 0, 1);
        cyc(8'h00, 8'h00, 0, 0, 1); vfy("R6 decrement");
      end
    end

    load(0, 16'h5555); load(1, 16'hAAAA);
    cyc(8'h86, 8'h00, 1, 0, 0);
    cyc(8'h00, 8'h00, 0, 1, 1); vfy("R7 both strobes");
    cyc(8'h82, 8'h10, 1, 1, 0); vfy("R8 write active low over inc");
    cyc(8'h83, 8'h20, 1, 0, 1); vfy("R8 write active high over dec");
    cyc(8'h84, 8'h77, 1, 1, 0); vfy("R9 write inactive with inc");
    cyc(8'h85, 8'h66, 1, 0, 1); vfy("R9 write inactive with dec");
    cyc(8'h81, 8'hEE, 1, 0, 0); vfy("R10 write unmapped 81");
    cyc(8'h87, 8'hEE, 1, 0, 0); vfy("R10 write unmapped 87");
    rd("R10 read unmapped", 8'h00, 8'h00);
    rd("R10 read unmapped", 8'hFF, 8'h00);
    cyc(8'h86, 8'h01, 1, 1, 0); vfy("R11 select change with inc");
    cyc(8'h86, 8'h00, 1, 0, 1); vfy("R11 select change with dec");
    load(0, 16'hFFFF); cyc(8'h00, 8'h00, 0, 1, 0); vfy("R5 full wrap");
    cyc(8'h00, 8'h00, 0, 0, 1); vfy("R6 full wrap");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule